// File: doc/BRIEF.md
# NAND Flash Strobe Timing Sequencer

This block turns a single host request into one correctly timed bus cycle on an 8-bit raw NAND device. A request names the kind of access (command byte, address byte or data byte) and, for data, the direction. The sequencer then runs three phases. In the setup phase the latch-enable lines and the write data are stable and the strobe is inactive. In the strobe phase the write or read strobe is held low. In the hold phase the strobe is high again while the lines stay put. An optional ready-wait phase can follow before the block samples the device's ready/busy line. A one-cycle done pulse closes the access.

All phase lengths come from a 32-bit timing word. The word holds separate setup, pulse-width, hold and ready-wait fields for write cycles and for read cycles, so the two directions can be tuned independently. Command and address bytes always use the write timing.

Requests use a valid/ready handshake. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low from acceptance until the cycle after the done pulse, and while it is low `req_valid` and the request fields have no effect. The response side (`rsp_done`, `rsp_rdata`, `rsp_rdy`) has no back-pressure. The done pulse lasts one cycle, and the response values stay valid until a later access replaces them.

Top module: `nand_strobe_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to idle. After that edge `req_ready` is 1, both strobes are high, `nand_cle`, `nand_ale`, `nand_dq_oe` and `rsp_done` are 0, `rsp_rdata` and `rsp_rdy` are 0, and `nand_ce_n` is 1 while `ce_force` is 0. This holds even if an access was in progress.
- R2: Timing word fields, each 4 bits wide, from the top bit down: write ready-wait [31:28], write width [27:24], write hold [23:20], write setup [19:16], read ready-wait [15:12], read width [11:8], read hold [7:4], read setup [3:0]. A write cycle uses only the write fields and a read cycle uses only the read fields.
- R3: Let the request be accepted at edge k, with setup, width and hold fields S, W and H. The setup phase (strobe high) then fills the S+1 cycles after edge k. The selected strobe is low for the next W+1 cycles. The hold phase (strobe high, latch enables and data unchanged) lasts H+1 cycles. Field value 0 means 1 clock and 15 means 16 clocks.
- R4: If `req_wait_rdy` was 1 at acceptance and the selected ready-wait field is n, exactly 2*n extra cycles follow the hold phase. If the flag was 0 or n is 0, no wait cycles are added. `rsp_done` is high for one cycle immediately after the last hold or wait cycle. `rsp_rdy` then holds the `nand_rb` level present in that last cycle.
- R5: Kind encoding on `req_kind`: 00 is a command, 01 is an address, 10 and 11 are data. A command drives `nand_cle` high and an address drives `nand_ale` high, in each case through setup, strobe and hold. Both are write cycles whatever `req_write` says: the write strobe pulses, and `nand_dq_out` carries `req_wdata` with `nand_dq_oe` high over the same span.
- R6: A data access has both latch enables low. With `req_write` 1 it is a write cycle, as in R5. With `req_write` 0 the read strobe pulses and `nand_dq_oe` stays 0. `rsp_rdata` takes the `nand_dq_in` value from the last strobe-low cycle and keeps it until the next read.
- R7: `nand_ce_n` is low whenever an access is in progress (from acceptance until `req_ready` returns) or `ce_force` is 1, and high otherwise.
- R8: `req_ready` is high only while idle. While it is low, requests and changes to the request fields have no effect. The timing word, kind, direction, data and wait flag are captured at acceptance, so later changes do not alter the running access.
- R9: The write and read strobes are never low in the same cycle, and neither is low outside an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| timing_word | input | 32 | Read and write phase counts |
| ce_force | input | 1 | Keep chip enable asserted between accesses |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_kind | input | 2 | 00 command, 01 address, 1x data |
| req_write | input | 1 | Data direction: 1 write, 0 read |
| req_wdata | input | 8 | Byte to drive on write cycles |
| req_wait_rdy | input | 1 | Add ready-wait phase to this access |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| rsp_rdy | output | 1 | Ready/busy level sampled at end of last access |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Device ready (1) / busy (0) |

## Verification
A wrong phase state or counter value reaches the pins within one cycle. It shows as a strobe edge one clock early or late, a latch enable dropping inside the hold phase, or a done pulse shifted against the expected 2*n wait. The reference model compares every pin in every cycle, so that kind of fault appears on the first cycle where the sequence diverges. A wrong snapshot of direction or fields shows either as the wrong strobe pulsing or as read phase lengths used for a write. A capture on the wrong edge shows up as soon as `rsp_rdata` is compared, because the bench changes `nand_dq_in` on every cycle.

// File: rtl/nss_pkg.sv
package nss_pkg;

  // Access progress; the order is the order the sequencer walks through.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RWAIT,
    PH_DONE
  } phase_t;

  localparam logic [1:0] KIND_CMD  = 2'b00;
  localparam logic [1:0] KIND_ADDR = 2'b01;

  // Slot positions inside one direction's half of the timing word.
  localparam int SLOT_SETUP    = 0;
  localparam int SLOT_HOLD     = 1;
  localparam int SLOT_WIDTH    = 2;
  localparam int SLOT_WAIT     = 3;
  localparam int SLOTS_PER_DIR = 4;
  localparam int NUM_SLOTS     = 2 * SLOTS_PER_DIR;

  // Command and address bytes always go out as write cycles.
  function automatic logic access_is_write(input logic [1:0] kind, input logic wr);
    return !kind[1] || wr;
  endfunction

endpackage

// File: rtl/nss_timing_sel.sv
module nss_timing_sel
  import nss_pkg::*;
#(
  parameter int FIELD_W = 4,
  localparam int WORD_W = FIELD_W * NUM_SLOTS,
  localparam int CNT_W  = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               is_write,
  input  logic [WORD_W-1:0]  timing_word,
  output logic [FIELD_W-1:0] setup_lim,
  output logic [FIELD_W-1:0] width_lim,
  output logic [FIELD_W-1:0] hold_lim,
  output logic [CNT_W-1:0]   wait_len
);

  localparam int WR_BASE = SLOTS_PER_DIR;

  logic [FIELD_W-1:0] slot [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot[g] = timing_word[g*FIELD_W +: FIELD_W];
  end

  int base;
  assign base = is_write ? WR_BASE : 0;

  // Snapshot the selected direction's fields when a request is taken.
  always_ff @(posedge clk) begin
    if (rst) begin
      setup_lim <= '0;
      width_lim <= '0;
      hold_lim  <= '0;
      wait_len  <= '0;
    end else if (load) begin
      setup_lim <= slot[base + SLOT_SETUP];
      width_lim <= slot[base + SLOT_WIDTH];
      hold_lim  <= slot[base + SLOT_HOLD];
      wait_len  <= {slot[base + SLOT_WAIT], 1'b0};
    end
  end

endmodule

// File: rtl/nss_phase_ctrl.sv
module nss_phase_ctrl
  import nss_pkg::*;
#(
  parameter int FIELD_W = 4,
  localparam int CNT_W  = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               wait_req,
  input  logic [FIELD_W-1:0] setup_lim,
  input  logic [FIELD_W-1:0] width_lim,
  input  logic [FIELD_W-1:0] hold_lim,
  input  logic [CNT_W-1:0]   wait_len,
  input  logic               nand_rb,
  output phase_t             phase,
  output logic               strobe_last,
  output logic               idle,
  output logic               done,
  output logic               rdy_level
);

  phase_t          ph;
  logic [CNT_W-1:0] cnt;
  logic             wait_q;
  logic             rdy_q;

  logic setup_end, width_end, hold_end, wait_end, need_wait;

  // One shared counter; each phase ends when it reaches that phase's limit.
  assign setup_end = (cnt == {1'b0, setup_lim});
  assign width_end = (cnt == {1'b0, width_lim});
  assign hold_end  = (cnt == {1'b0, hold_lim});
  assign wait_end  = (cnt == wait_len - 1'b1);
  assign need_wait = wait_q && (wait_len != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      wait_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph     <= PH_SETUP;
            cnt    <= '0;
            wait_q <= wait_req;
          end
        end
        PH_SETUP: begin
          if (setup_end) begin
            ph  <= PH_STROBE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_STROBE: begin
          if (width_end) begin
            ph  <= PH_HOLD;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HOLD: begin
          if (hold_end) begin
            cnt <= '0;
            if (need_wait) begin
              ph <= PH_RWAIT;
            end else begin
              ph    <= PH_DONE;
              rdy_q <= nand_rb;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RWAIT: begin
          if (wait_end) begin
            ph    <= PH_DONE;
            cnt   <= '0;
            rdy_q <= nand_rb;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DONE: ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign phase       = ph;
  assign strobe_last = (ph == PH_STROBE) && width_end;
  assign idle        = (ph == PH_IDLE);
  assign done        = (ph == PH_DONE);
  assign rdy_level   = rdy_q;

endmodule

// File: rtl/nss_pin_drive.sv
module nss_pin_drive
  import nss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        kind,
  input  logic              is_write,
  input  logic [DATA_W-1:0] wdata,
  input  phase_t            phase,
  input  logic              strobe_last,
  input  logic              ce_force,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata
);

  logic [1:0]        kind_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q  <= KIND_CMD;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        kind_q  <= kind;
        wr_q    <= is_write;
        wdata_q <= wdata;
      end
      // Capture on the edge that closes the read strobe.
      if (strobe_last && !wr_q) begin
        rdata_q <= dq_in;
      end
    end
  end

  logic in_cycle, strobing;
  assign in_cycle = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobing = (phase == PH_STROBE);

  assign cle    = in_cycle && (kind_q == KIND_CMD);
  assign ale    = in_cycle && (kind_q == KIND_ADDR);
  assign we_n   = !(strobing && wr_q);
  assign re_n   = !(strobing && !wr_q);
  assign dq_oe  = in_cycle && wr_q;
  assign dq_out = wdata_q;
  assign ce_n   = !(ce_force || (phase != PH_IDLE));
  assign rdata  = rdata_q;

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nss_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 4,
  localparam int WORD_W = FIELD_W * NUM_SLOTS,
  localparam int CNT_W  = FIELD_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] timing_word,
  input  logic              ce_force,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_wait_rdy,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_rdy,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb
);

  logic               idle, start, wr_eff, strobe_last;
  logic [FIELD_W-1:0] setup_lim, width_lim, hold_lim;
  logic [CNT_W-1:0]   wait_len;
  phase_t             phase;

  assign req_ready = idle;
  assign start     = req_valid && idle;
  assign wr_eff    = access_is_write(req_kind, req_write);

  nss_timing_sel #(.FIELD_W(FIELD_W)) u_tsel (
    .clk         (clk),
    .rst         (rst),
    .load        (start),
    .is_write    (wr_eff),
    .timing_word (timing_word),
    .setup_lim   (setup_lim),
    .width_lim   (width_lim),
    .hold_lim    (hold_lim),
    .wait_len    (wait_len)
  );

  nss_phase_ctrl #(.FIELD_W(FIELD_W)) u_phase (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .wait_req    (req_wait_rdy),
    .setup_lim   (setup_lim),
    .width_lim   (width_lim),
    .hold_lim    (hold_lim),
    .wait_len    (wait_len),
    .nand_rb     (nand_rb),
    .phase       (phase),
    .strobe_last (strobe_last),
    .idle        (idle),
    .done        (rsp_done),
    .rdy_level   (rsp_rdy)
  );

  nss_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .kind        (req_kind),
    .is_write    (wr_eff),
    .wdata       (req_wdata),
    .phase       (phase),
    .strobe_last (strobe_last),
    .ce_force    (ce_force),
    .dq_in       (nand_dq_in),
    .ce_n        (nand_ce_n),
    .cle         (nand_cle),
    .ale         (nand_ale),
    .we_n        (nand_we_n),
    .re_n        (nand_re_n),
    .dq_out      (nand_dq_out),
    .dq_oe       (nand_dq_oe),
    .rdata       (rsp_rdata)
  );

endmodule

// File: rtl/nss_chk.sv
module nss_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_force,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              nand_ce_n,
  input logic              nand_cle,
  input logic              nand_ale,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic [DATA_W-1:0] nand_dq_out,
  input logic              nand_dq_oe
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (req_ready && nand_we_n && nand_re_n && !nand_cle && !nand_ale
               && !nand_dq_oe && !rsp_done));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n));

  // R9
  strobe_in_access_chk: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n || !nand_re_n) |-> !req_ready);

  // R7
  ce_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> !nand_ce_n);

  // R7
  ce_release_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !ce_force) |-> nand_ce_n);

  // R5
  cmd_is_write_chk: assert property (@(posedge clk) disable iff (rst)
    (nand_cle || nand_ale) |-> (nand_re_n && !(nand_cle && nand_ale)));

  // R6
  read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !nand_dq_oe);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> (!rsp_done && req_ready));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !req_valid) |=> req_ready);

  // R8
  wdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (nand_dq_oe && $past(nand_dq_oe)) |-> $stable(nand_dq_out));

endmodule

bind nand_strobe_seq nss_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ce_force    (ce_force),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .nand_ce_n   (nand_ce_n),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n),
  .nand_dq_out (nand_dq_out),
  .nand_dq_oe  (nand_dq_oe)
);

// File: tb/sim_nand_strobe_seq.sv
`timescale 1ns/1ps
module sim_nand_strobe_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] timing_word = '0;
  logic        ce_force = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'b00;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        req_wait_rdy = 1'b0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic        rsp_rdy;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb = 1'b1;

  always #5 clk = ~clk;

  nand_strobe_seq u0 (
    .clk(clk), .rst(rst), .timing_word(timing_word), .ce_force(ce_force),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_write(req_write), .req_wdata(req_wdata), .req_wait_rdy(req_wait_rdy),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_rdy(rsp_rdy),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Device data bus changes every cycle so a mistimed capture is visible.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 nand_dq_in <= 8'(cyc * 29 + 7);
  end

  typedef struct packed {
    logic       cle, ale, we_n, re_n, oe;
    logic [7:0] dq;
    logic       done, cap, samp;
  } ent_t;

  ent_t q[$];
  logic [7:0] exp_rdata = '0;
  logic       exp_rdy = 1'b0;
  logic       pend_rd = 1'b0, pend_rb = 1'b0;
  logic [7:0] pend_rd_val = '0;
  logic       pend_rb_val = 1'b0;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, expv);
    end
  endtask

  // Expected per-cycle pin sequence for one accepted request (R2..R6).
  function automatic void push_seq(input logic [1:0] k, input logic w, input logic [7:0] d,
                                   input logic wt, input logic [31:0] tw);
    logic wr;
    int base, s, h, wd, n, wcnt;
    ent_t e;
    wr   = !k[1] || w;
    base = wr ? 16 : 0;
    s    = int'(tw[base +: 4]);
    h    = int'(tw[base + 4 +: 4]);
    wd   = int'(tw[base + 8 +: 4]);
    n    = int'(tw[base + 12 +: 4]);
    wcnt = wt ? 2 * n : 0;
    e = '0;
    e.cle = (k == 2'b00);
    e.ale = (k == 2'b01);
    e.oe  = wr;
    e.dq  = d;
    e.we_n = 1'b1; e.re_n = 1'b1;
    for (int i = 0; i <= s; i++) q.push_back(e);
    for (int i = 0; i <= wd; i++) begin
      ent_t t = e;
      t.we_n = !wr;
      t.re_n = wr;
      t.cap  = !wr && (i == wd);
      q.push_back(t);
    end
    for (int i = 0; i <= h; i++) begin
      ent_t t = e;
      t.samp = (wcnt == 0) && (i == h);
      q.push_back(t);
    end
    for (int i = 0; i < wcnt; i++) begin
      ent_t t = '0;
      t.we_n = 1'b1; t.re_n = 1'b1;
      t.samp = (i == wcnt - 1);
      q.push_back(t);
    end
    begin
      ent_t t = '0;
      t.we_n = 1'b1; t.re_n = 1'b1; t.done = 1'b1;
      q.push_back(t);
    end
  endfunction

  // Reference model: compare every pin on every falling edge.
  always @(negedge clk) begin
    if (rst) begin
      q.delete();
      exp_rdata = '0; exp_rdy = 1'b0; pend_rd = 1'b0; pend_rb = 1'b0;
    end else begin
      ent_t e;
      logic busy;
      if (pend_rd) begin exp_rdata = pend_rd_val; pend_rd = 1'b0; end
      if (pend_rb) begin exp_rdy = pend_rb_val; pend_rb = 1'b0; end
      busy = (q.size() != 0);
      if (busy) e = q[0];
      else begin e = '0; e.we_n = 1'b1; e.re_n = 1'b1; end
      chk(req_ready == !busy, "R8", "req_ready", 32'(req_ready), 32'(!busy));
      chk(nand_cle == e.cle, "R5", "cle", 32'(nand_cle), 32'(e.cle));
      chk(nand_ale == e.ale, "R5", "ale", 32'(nand_ale), 32'(e.ale));
      chk(nand_we_n == e.we_n, "R3", "we_n (R2 write fields)", 32'(nand_we_n), 32'(e.we_n));
      chk(nand_re_n == e.re_n, "R3", "re_n (R2 read fields)", 32'(nand_re_n), 32'(e.re_n));
      chk(nand_dq_oe == e.oe, "R6", "dq_oe", 32'(nand_dq_oe), 32'(e.oe));
      if (e.oe) chk(nand_dq_out == e.dq, "R5", "dq_out", 32'(nand_dq_out), 32'(e.dq));
      chk(rsp_done == e.done, "R4", "rsp_done", 32'(rsp_done), 32'(e.done));
      chk(rsp_rdata == exp_rdata, "R6", "rsp_rdata", 32'(rsp_rdata), 32'(exp_rdata));
      chk(rsp_rdy == exp_rdy, "R4", "rsp_rdy", 32'(rsp_rdy), 32'(exp_rdy));
      chk(nand_ce_n == !(ce_force || busy), "R7", "ce_n", 32'(nand_ce_n), 32'(!(ce_force || busy)));
      if (busy) begin
        if (e.cap)  begin pend_rd = 1'b1; pend_rd_val = nand_dq_in; end
        if (e.samp) begin pend_rb = 1'b1; pend_rb_val = nand_rb; end
        void'(q.pop_front());
      end else if (req_valid) begin
        push_seq(req_kind, req_write, req_wdata, req_wait_rdy, timing_word);
      end
    end
  end

  task automatic issue(input logic [1:0] k, input logic w, input logic [7:0] d, input logic wt);
    @(posedge clk); #1;
    req_kind = k; req_write = w; req_wdata = d; req_wait_rdy = wt; req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!req_ready);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: idle pins right after reset
    chk(req_ready && nand_we_n && nand_re_n && !nand_cle && !nand_ale && nand_ce_n,
        "R1", "post-reset idle", {26'd0, req_ready, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_ce_n},
        32'b111001);

    timing_word = 32'h2312_1504;
    // R5: command then address, both write cycles even with req_write 0
    issue(2'b00, 1'b0, 8'h70, 1'b0); wait_idle();
    issue(2'b01, 1'b0, 8'h3C, 1'b1); wait_idle();
    // R6 write, then read; R2 distinct read/write timings
    issue(2'b10, 1'b1, 8'hA5, 1'b0); wait_idle();
    nand_rb = 1'b0;
    issue(2'b10, 1'b0, 8'h00, 1'b1); wait_idle();
    nand_rb = 1'b1;
    issue(2'b11, 1'b0, 8'h00, 1'b0); wait_idle();

    // R3 minimum fields, R4 zero wait even when requested
    timing_word = 32'h0000_0000;
    issue(2'b10, 1'b0, 8'h00, 1'b1); wait_idle();
    issue(2'b00, 1'b0, 8'hFF, 1'b1); wait_idle();
    // R3/R4 maximum fields: 16-clock phases and 30-cycle wait
    timing_word = 32'hFFFF_FFFF;
    issue(2'b10, 1'b0, 8'h00, 1'b1); wait_idle();
    issue(2'b10, 1'b1, 8'h5A, 1'b1); wait_idle();

    // R8: requests and timing changes during a busy access are ignored
    timing_word = 32'h4321_8765;
    issue(2'b10, 1'b1, 8'hC3, 1'b1);
    #1;
    req_valid = 1'b1; req_kind = 2'b00; req_wdata = 8'h11; timing_word = 32'h0000_0000;
    repeat (3) @(posedge clk);
    #1 req_valid = 1'b0;
    wait_idle();

    // R7: forced chip enable across accesses and released afterwards
    @(posedge clk); #1 ce_force = 1'b1;
    repeat (3) @(posedge clk);
    issue(2'b01, 1'b1, 8'h42, 1'b0); wait_idle();
    @(posedge clk); #1 ce_force = 1'b0;
    repeat (3) @(posedge clk);

    // R1: reset in the middle of an access
    timing_word = 32'h5555_5555;
    issue(2'b10, 1'b0, 8'h00, 1'b0);
    repeat (4) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready && nand_we_n && nand_re_n && !nand_cle && !nand_dq_oe && rsp_rdata == 8'h00,
        "R1", "mid-access reset", {24'd0, rsp_rdata}, 32'h0);
    issue(2'b00, 1'b1, 8'h90, 1'b1); wait_idle();

    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule